// File: doc/BRIEF.md
# Fence Register Detiling Window

A bank of fence registers. Each fence marks one page-aligned window of a linear aperture as tiled memory. Software programs every fence through a 32-bit write port as two halves. The low half carries the window start page, the pitch code, the tile layout and the enable. The high half carries the last page of the window.

Each aperture lookup is compared against all enabled fences. On a hit, the block reports which fence matched, the tile layout and the pitch code. It also returns the address rebuilt in tiled order: the tile column, then the tile row, then the offset inside the tile. On a miss the address passes through unchanged. A result appears one clock after its lookup.

Software must keep the window a whole number of tile rows long. A tile row is stride × 8 bytes for X tiling and stride × 32 bytes for Y tiling. Software updates a fence in three steps: clear the low half, write the high half, then write the low half with the enable set.

Top module: `fence_window`

## Requirements
- R1: A write with `wr_sel[0]`=0 loads the low half of fence `wr_sel[3:1]`. Its fields are: [31:12] start page, [11:4] pitch code (stride/128 − 1), [1] layout (1 = Y tiling, 0 = X tiling), [0] enable. Bits [3:2] are ignored.
- R2: A write with `wr_sel[0]`=1 loads the high half. Bits [31:12] hold the last page of the window (start + size − 4096). Bits [11:0] are ignored.
- R3: A lookup hits a fence only while that fence is enabled and start ≤ `in_addr[31:12]` ≤ last page. Both bounds are inclusive.
- R4: When several fences hit, the fence with the lowest index wins.
- R5: A high-half write clears that fence's enable. The fence then never matches until a low-half write sets the enable again.
- R6: Writing zero to both halves disables a fence.
- R7: `out_valid` is high exactly one cycle after each cycle in which `in_valid` is high. When `out_valid` is high, exactly one of `out_hit` and `out_miss` is set.
- R8: On a miss, `out_addr` equals the lookup address, and `out_index`, `out_tile_y` and `out_pitch` are zero.
- R9: On a hit, `out_index`, `out_tile_y` and `out_pitch` report the winning fence's index, layout bit and pitch code.
- R10: X tiling uses tiles of 512 B × 8 rows. With S = (pitch code + 1) × 128, off = addr − start, y = off / S and x = off mod S, the result is start + (y/8)·8S + (x/512)·4096 + (y mod 8)·512 + x mod 512.
- R11: Y tiling uses tiles of 128 B × 32 rows. The result is start + (y/32)·32S + (x/128)·4096 + (y mod 32)·128 + x mod 128.
- R12: A lookup made in the same cycle as a fence write sees the fence state from before that write.
- R13: After reset, all fences are disabled and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Fence write strobe |
| wr_sel | input | 4 | [3:1] fence index, [0] half (0 low, 1 high) |
| wr_data | input | 32 | Write data |
| in_valid | input | 1 | Lookup request |
| in_addr | input | 32 | Aperture address to look up |
| out_valid | output | 1 | Result valid, one cycle after the lookup |
| out_hit | output | 1 | Lookup hit a fence |
| out_miss | output | 1 | Lookup hit no fence |
| out_index | output | 3 | Winning fence index |
| out_tile_y | output | 1 | Winning fence uses Y tiling |
| out_pitch | output | 8 | Winning fence pitch code |
| out_addr | output | 32 | Tiled address on a hit, the lookup address on a miss |

## Verification
Every cycle, the assertions check the one-cycle valid timing and that hit and miss are mutually exclusive. They also check that a miss returns the lookup address with zeroed fields, and that a hit keeps the seven low address bits. Only the bench scenarios can show which fence wins an overlap, and where the window bounds fall. The same goes for the exact X and Y tiled addresses, the disable caused by a high-half write, and the fact that a lookup sees the fence state from before a write in the same cycle.

// File: rtl/fence_window.sv
module fence_window #(
  parameter int N  = 8,
  parameter int PW = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW:0]   wr_sel,
  input  logic [31:0]   wr_data,
  input  logic          in_valid,
  input  logic [31:0]   in_addr,
  output logic          out_valid,
  output logic          out_hit,
  output logic          out_miss,
  output logic [IW-1:0] out_index,
  output logic          out_tile_y,
  output logic [PW-1:0] out_pitch,
  output logic [31:0]   out_addr
);
  logic [19:0]   st [N];
  logic [19:0]   en [N];
  logic [PW-1:0] pc [N];
  logic          ty [N];
  logic          vl [N];

  logic [IW-1:0] wi;
  assign wi = wr_sel[IW:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        st[i] <= '0; en[i] <= '0; pc[i] <= '0; ty[i] <= 1'b0; vl[i] <= 1'b0;
      end
    end else if (wr_en) begin
      if (!wr_sel[0]) begin
        st[wi] <= wr_data[31:12];
        pc[wi] <= wr_data[PW+3:4];
        ty[wi] <= wr_data[1];
        vl[wi] <= wr_data[0];
      end else begin
        en[wi] <= wr_data[31:12];
        vl[wi] <= 1'b0;
      end
    end
  end

  logic [N-1:0] m;
  for (genvar g = 0; g < N; g++) begin : g_match
    assign m[g] = vl[g] && (in_addr[31:12] >= st[g]) && (in_addr[31:12] <= en[g]);
  end

  logic [IW-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--)
      if (m[i]) sel = IW'(i);
  end

  logic          hit;
  logic [19:0]   sb;
  logic [PW-1:0] sp;
  logic          sy;
  assign hit = |m;
  assign sb  = st[sel];
  assign sp  = pc[sel];
  assign sy  = ty[sel];

  logic [31:0]   base, off;
  logic [24:0]   q, yr, rm;
  logic [PW:0]   dv;
  logic [PW+7:0] x;
  assign base = {sb, 12'h000};
  assign off  = in_addr - base;
  assign q    = off[31:7];
  assign dv   = {1'b0, sp} + 1'b1;
  assign yr   = q / 25'(dv);
  assign rm   = q % 25'(dv);
  assign x    = {rm[PW:0], off[6:0]};

  logic [31:0] rbx, cx, ix, rby, cy, iy, tiled;
  assign rbx = (32'(yr[24:3]) * 32'(dv)) << 10;
  assign cx  = 32'(x[PW+7:9]) << 12;
  assign ix  = {20'h0, yr[2:0], x[8:0]};
  assign rby = (32'(yr[24:5]) * 32'(dv)) << 12;
  assign cy  = 32'(x[PW+7:7]) << 12;
  assign iy  = {20'h0, yr[4:0], x[6:0]};
  assign tiled = sy ? (rby + cy + iy) : (rbx + cx + ix);

  logic unused_bits;
  assign unused_bits = ^{wr_data[3:2], wr_data[11:0], rm[24:PW+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_hit    <= 1'b0;
      out_miss   <= 1'b0;
      out_index  <= '0;
      out_tile_y <= 1'b0;
      out_pitch  <= '0;
      out_addr   <= '0;
    end else begin
      out_valid  <= in_valid;
      out_hit    <= in_valid && hit;
      out_miss   <= in_valid && !hit;
      out_index  <= (in_valid && hit) ? sel : '0;
      out_tile_y <= in_valid && hit && sy;
      out_pitch  <= (in_valid && hit) ? sp : '0;
      out_addr   <= !in_valid ? '0 : (hit ? base + tiled : in_addr);
    end
  end
endmodule

module fence_window_chk #(
  parameter int N  = 8,
  parameter int PW = 8,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [31:0]   in_addr,
  input logic          out_valid,
  input logic          out_hit,
  input logic          out_miss,
  input logic [IW-1:0] out_index,
  input logic          out_tile_y,
  input logic [PW-1:0] out_pitch,
  input logic [31:0]   out_addr
);
  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R7
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({out_hit, out_miss}) == 1);
  // R7
  quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_hit && !out_miss);
  // R8
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid ##1 out_miss |-> out_addr == $past(in_addr));
  // R8
  miss_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_miss |-> out_index == '0 && !out_tile_y && out_pitch == '0);
  // R10
  hit_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid ##1 out_hit |-> out_addr[6:0] == $past(in_addr[6:0]));
endmodule

bind fence_window fence_window_chk #(.N(N), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
  .out_valid(out_valid), .out_hit(out_hit), .out_miss(out_miss),
  .out_index(out_index), .out_tile_y(out_tile_y), .out_pitch(out_pitch),
  .out_addr(out_addr)
);

// File: tb/fence_window_test.sv
module fence_window_test;
  localparam int CLK_NS = 10;

  typedef struct packed {
    logic        hit;
    logic [2:0]  idx;
    logic        ty;
    logic [7:0]  pitch;
    logic [31:0] addr;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, in_valid = 1'b0;
  logic [3:0] wr_sel = '0;
  logic [31:0] wr_data = '0, in_addr = '0;
  logic out_valid, out_hit, out_miss, out_tile_y;
  logic [2:0] out_index;
  logic [7:0] out_pitch;
  logic [31:0] out_addr;

  fence_window uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .in_valid(in_valid), .in_addr(in_addr), .out_valid(out_valid),
    .out_hit(out_hit), .out_miss(out_miss), .out_index(out_index),
    .out_tile_y(out_tile_y), .out_pitch(out_pitch), .out_addr(out_addr)
  );

  always #(CLK_NS / 2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  exp_t  exp_q[$];
  string tag_q[$];
  logic [31:0] mlo [8];
  logic [31:0] mhi [8];

  function automatic logic [31:0] lo_word(logic [19:0] pg, logic [7:0] p, logic y, logic v);
    return {pg, p, 2'b00, y, v};
  endfunction

  function automatic exp_t model(logic [31:0] a);
    exp_t e;
    longint s, o, yy, xx, t;
    int w;
    e = '0;
    e.addr = a;
    w = -1;
    for (int i = 7; i >= 0; i--)
      if (mlo[i][0] && a[31:12] >= mlo[i][31:12] && a[31:12] <= mhi[i][31:12]) w = i;
    if (w >= 0) begin
      s  = (longint'(mlo[w][11:4]) + 1) * 128;
      o  = longint'(a) - longint'({mlo[w][31:12], 12'h000});
      yy = o / s;
      xx = o % s;
      if (mlo[w][1]) t = (yy / 32) * s * 32 + (xx / 128) * 4096 + (yy % 32) * 128 + xx % 128;
      else           t = (yy / 8) * s * 8 + (xx / 512) * 4096 + (yy % 8) * 512 + xx % 512;
      e.hit = 1'b1;
      e.idx = 3'(w);
      e.ty = mlo[w][1];
      e.pitch = mlo[w][11:4];
      e.addr = 32'(longint'({mlo[w][31:12], 12'h000}) + t);
    end
    return e;
  endfunction

  function automatic void model_wr(logic [3:0] s, logic [31:0] d);
    if (!s[0]) mlo[s[3:1]] = d;
    else begin mhi[s[3:1]] = d; mlo[s[3:1]][0] = 1'b0; end
  endfunction

  task automatic wr(logic [2:0] f, logic h, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = {f, h}; wr_data = d; in_valid = 1'b0;
    model_wr({f, h}, d);
  endtask

  task automatic look(logic [31:0] a, string tag);
    @(negedge clk);
    wr_en = 1'b0; in_valid = 1'b1; in_addr = a;
    exp_q.push_back(model(a)); tag_q.push_back(tag);
  endtask

  task automatic look_wr(logic [31:0] a, logic [2:0] f, logic h, logic [31:0] d, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    exp_q.push_back(model(a)); tag_q.push_back(tag);
    wr_en = 1'b1; wr_sel = {f, h}; wr_data = d;
    model_wr({f, h}, d);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      wr_en = 1'b0; in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R7: unexpected result addr=%h expected no result", out_addr);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (out_hit !== e.hit || out_miss !== !e.hit || out_index !== e.idx ||
            out_tile_y !== e.ty || out_pitch !== e.pitch || out_addr !== e.addr) begin
          n_bad++;
          $display("FAIL %s: got hit=%b idx=%0d y=%b p=%0d addr=%h expected hit=%b idx=%0d y=%b p=%0d addr=%h",
                   t, out_hit, out_index, out_tile_y, out_pitch, out_addr,
                   e.hit, e.idx, e.ty, e.pitch, e.addr);
        end
      end
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_NS * 50000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mlo[i] = '0; mhi[i] = '0; end
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_addr !== '0 || out_hit !== 1'b0) begin
      n_bad++;
      $display("FAIL R13: reset outputs valid=%b addr=%h expected 0/0", out_valid, out_addr);
    end
    rst_n = 1'b1;
    look(32'h0010_1234, "R13");
    idle(1);

    // fence 0: X, stride 2048, pages 0x100..0x10F
    wr(3'd0, 1'b0, 32'h0);
    wr(3'd0, 1'b1, {20'h0010F, 12'h0});
    wr(3'd0, 1'b0, lo_word(20'h00100, 8'd15, 1'b0, 1'b1) | 32'h0000_000C);
    // fence 1: Y, stride 512, pages 0x200..0x20F
    wr(3'd1, 1'b1, {20'h0020F, 12'hFFF});
    wr(3'd1, 1'b0, lo_word(20'h00200, 8'd3, 1'b1, 1'b1));
    // fence 5: X, stride 4096, pages 0x300..0x30F; fence 2: Y, pages 0x308..0x30F
    wr(3'd5, 1'b1, {20'h0030F, 12'h0});
    wr(3'd5, 1'b0, lo_word(20'h00300, 8'd31, 1'b0, 1'b1));
    wr(3'd2, 1'b1, {20'h0030F, 12'h0});
    wr(3'd2, 1'b0, lo_word(20'h00308, 8'd7, 1'b1, 1'b1));
    idle(1);

    look(32'h0010_1388, "R10");
    look(32'h0010_0000, "R10");
    look(32'h0010_7ABC, "R10");
    look(32'h0010_FFFF, "R3");
    look(32'h0011_0000, "R3");
    look(32'h000F_FFFF, "R3");
    look(32'h0020_0000, "R11");
    look(32'h0020_1234, "R11");
    look(32'h0020_9F77, "R11");
    look(32'h0030_9000, "R4");
    look(32'h0030_1000, "R9");
    look(32'h0030_F123, "R4");
    idle(2);

    wr(3'd0, 1'b1, {20'h0011F, 12'h0});
    look(32'h0010_1388, "R5");
    look(32'h0011_8000, "R5");
    wr(3'd0, 1'b0, lo_word(20'h00100, 8'd15, 1'b0, 1'b1));
    look(32'h0011_8000, "R2");
    idle(1);

    wr(3'd1, 1'b0, 32'h0);
    wr(3'd1, 1'b1, 32'h0);
    look(32'h0020_1234, "R6");
    idle(1);

    look_wr(32'h0010_2000, 3'd0, 1'b0, 32'h0, "R12");
    look(32'h0010_2000, "R12");
    wr(3'd3, 1'b1, {20'h0040F, 12'h0});
    wr(3'd3, 1'b0, lo_word(20'h00400, 8'd7, 1'b1, 1'b1));
    look(32'h0040_5432, "R1");
    idle(4);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R7: %0d results missing expected 0", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule